// File: doc/BRIEF.md
# Multi-Mode UART Baud Generator

This block divides the UART input clock into two strobes: a sample tick that clocks the receiver's oversampling logic and a bit tick that paces the transmitter. A 16-bit base divisor A sets the prescaler period to A + 2 input-clock cycles. Each prescaler wrap produces one sample tick. A second counter groups these sample ticks into bit periods. Two mode-select inputs set the group size: a fixed 16, a programmable B + 1 taken from a 4-bit extra divisor, or 1 (direct division).

Some modes have lower limits on their divisors. If a setting breaks one of these limits, the block raises a configuration-error flag and emits no ticks. The block watches all of its configuration inputs. Whenever any of them changes, both counters restart from zero, so the first tick after a change comes one full new period later.

Top module: `baud_gen`

## Requirements
- R1: While `rst` is high, `sample_tick`, `bit_tick` and `cfg_err` are low, and both counters are held at zero.
- R2: With `ovs_sel_en` = 0 (sixteen-fold mode), a sample tick occurs every A + 2 cycles and a bit tick every 16 × (A + 2) cycles.
- R3: With `ovs_sel_en` = 1 and `ovs_bypass` = 0 (programmable mode) and B ≥ 8, a bit tick occurs every (B + 1) × (A + 2) cycles, and sample ticks occur every A + 2 cycles.
- R4: With `ovs_sel_en` = 1 and `ovs_bypass` = 1 (direct mode) and A ≥ 3, both ticks occur together every A + 2 cycles, and the value of B has no effect on them.
- R5: When `ovs_sel_en` = 0, the value of `ovs_bypass` has no effect.
- R6: In programmable mode with B < 8, `cfg_err` is high and no tick occurs.
- R7: In direct mode with A < 3, `cfg_err` is high and no tick occurs.
- R8: A change on any configuration input is captured at the next clock edge. Number the cycle that follows that edge as cycle 0. The first sample tick then falls in cycle A + 1, and the first bit tick falls in cycle N × (A + 2) − 1, where N is 16, B + 1 or 1 depending on the mode.
- R9: Each tick is high for exactly one cycle. A bit tick only occurs in a cycle that also has a sample tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | UART input clock |
| rst | input | 1 | Synchronous active-high reset |
| div_base | input | 16 | Base divisor A; the prescaler period is A + 2 |
| div_ext | input | 4 | Extra divisor B, used in programmable mode |
| ovs_sel_en | input | 1 | 0 selects sixteen-fold mode; 1 selects programmable or direct mode |
| ovs_bypass | input | 1 | When `ovs_sel_en` = 1: 0 selects programmable mode, 1 selects direct mode |
| sample_tick | output | 1 | One-cycle strobe at each prescaler wrap |
| bit_tick | output | 1 | One-cycle strobe once per bit period |
| cfg_err | output | 1 | High while the settings break a mode limit |

## Verification
Assertions check on every cycle that:
- no tick occurs while the error flag is high;
- each tick lasts one cycle and no tick follows directly after a restart;
- both counters stay inside the bounds set by the captured configuration;
- in direct mode, the two ticks coincide.

The exact tick periods, the phase of the first tick after a change, and the fact that B and the bypass bit are ignored in the modes that do not use them can only be shown by the bench. It sweeps many divisor pairs in every mode and compares each cycle with arithmetic expectations.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    typedef enum logic [1:0] {
        MODE_OVS16  = 2'd0,
        MODE_PROG   = 2'd1,
        MODE_DIRECT = 2'd2
    } baud_mode_e;

    localparam int unsigned OVS_FIXED     = 16;
    localparam int unsigned EXT_MIN       = 8;
    localparam int unsigned BASE_MIN_DIR  = 3;

    function automatic baud_mode_e decode_mode(input logic sel_en, input logic bypass);
        if (!sel_en)     return MODE_OVS16;
        else if (bypass) return MODE_DIRECT;
        else             return MODE_PROG;
    endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
    import baud_gen_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned BW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base_in,
    input  logic [BW-1:0] ext_in,
    input  logic          sel_en_in,
    input  logic          bypass_in,
    output logic [AW-1:0] base_q,
    output logic [BW-1:0] ext_q,
    output baud_mode_e    mode_q,
    output logic          restart,
    output logic          err
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [BW-1:0] ext;
        logic          sel_en;
        logic          bypass;
    } cfg_t;

    cfg_t cfg_in, cfg_q;

    always_comb begin
        cfg_in.base   = base_in;
        cfg_in.ext    = ext_in;
        cfg_in.sel_en = sel_en_in;
        cfg_in.bypass = bypass_in;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_in;
    end

    assign restart = (cfg_in != cfg_q);
    assign base_q  = cfg_q.base;
    assign ext_q   = cfg_q.ext;
    assign mode_q  = decode_mode(cfg_q.sel_en, cfg_q.bypass);

    always_comb begin
        unique case (mode_q)
            MODE_PROG:   err = (32'(cfg_q.ext)  < EXT_MIN);
            MODE_DIRECT: err = (32'(cfg_q.base) < BASE_MIN_DIR);
            default:     err = 1'b0;
        endcase
    end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          run,
    input  logic [AW-1:0] base,
    output logic          strobe
);
    localparam int unsigned PW = AW + 1;

    logic [PW-1:0] cnt, lim;

    assign lim    = {1'b0, base} + PW'(1);
    assign strobe = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) cnt <= '0;
        else if (cnt == lim)        cnt <= '0;
        else                        cnt <= cnt + PW'(1);
    end

    // R2: prescaler never runs past its wrap value
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim);
endmodule

// File: rtl/baud_bitdiv.sv
module baud_bitdiv
    import baud_gen_pkg::*;
#(
    parameter int unsigned BW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          run,
    input  logic          strobe,
    input  baud_mode_e    mode,
    input  logic [BW-1:0] ext,
    output logic          tick
);
    localparam int unsigned OW = $clog2(OVS_FIXED);
    localparam int unsigned DW = ((BW > OW) ? BW : OW) + 1;

    logic [DW-1:0] dcnt, span_m1;

    always_comb begin
        unique case (mode)
            MODE_PROG:   span_m1 = DW'(ext);
            MODE_DIRECT: span_m1 = '0;
            default:     span_m1 = DW'(OVS_FIXED - 1);
        endcase
    end

    assign tick = run && strobe && (dcnt == span_m1);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) dcnt <= '0;
        else if (strobe) begin
            if (dcnt == span_m1) dcnt <= '0;
            else                 dcnt <= dcnt + DW'(1);
        end
    end

    // R3: group counter stays within the selected span
    a_r3_dcnt_bound: assert property (@(posedge clk) disable iff (rst)
        dcnt <= span_m1);
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_gen_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned BW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] div_base,
    input  logic [BW-1:0] div_ext,
    input  logic          ovs_sel_en,
    input  logic          ovs_bypass,
    output logic          sample_tick,
    output logic          bit_tick,
    output logic          cfg_err
);
    logic [AW-1:0] base_q;
    logic [BW-1:0] ext_q;
    baud_mode_e    mode_q;
    logic          restart, err, run;

    baud_cfg_reg #(.AW(AW), .BW(BW)) u_cfg (
        .clk(clk), .rst(rst),
        .base_in(div_base), .ext_in(div_ext),
        .sel_en_in(ovs_sel_en), .bypass_in(ovs_bypass),
        .base_q(base_q), .ext_q(ext_q), .mode_q(mode_q),
        .restart(restart), .err(err)
    );

    assign run = !err;

    baud_prescaler #(.AW(AW)) u_pre (
        .clk(clk), .rst(rst), .restart(restart), .run(run),
        .base(base_q), .strobe(sample_tick)
    );

    baud_bitdiv #(.BW(BW)) u_div (
        .clk(clk), .rst(rst), .restart(restart), .run(run),
        .strobe(sample_tick), .mode(mode_q), .ext(ext_q),
        .tick(bit_tick)
    );

    assign cfg_err = err;

    // R6 / R7: a rejected setting silences both strobes
    a_r6_err_silent: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!sample_tick && !bit_tick));
    // R9: strobes last a single cycle
    a_r9_sample_single: assert property (@(posedge clk) disable iff (rst)
        sample_tick |=> !sample_tick);
    a_r9_bit_single: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);
    // R8: a captured change leaves no tick in the following cycle
    a_r8_restart_quiet: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!sample_tick && !bit_tick));
    // R4: direct mode fires both strobes together
    a_r4_direct_coincide: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DIRECT && sample_tick) |-> bit_tick);
endmodule

// File: tb/baud_gen_bench.sv
`timescale 1ns/1ps
module baud_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] div_base = '0;
    logic [3:0]  div_ext = '0;
    logic        ovs_sel_en = 1'b0;
    logic        ovs_bypass = 1'b0;
    logic        sample_tick, bit_tick, cfg_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    baud_gen u_baud_gen (
        .clk(clk), .rst(rst), .div_base(div_base), .div_ext(div_ext),
        .ovs_sel_en(ovs_sel_en), .ovs_bypass(ovs_bypass),
        .sample_tick(sample_tick), .bit_tick(bit_tick), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {sample,bit,err} actual %b expected %b (A=%0d B=%0d en=%0b byp=%0b)",
                     req, act, exp, div_base, div_ext, ovs_sel_en, ovs_bypass);
        end
    endtask

    // Apply a setting and compare every cycle of a window against arithmetic.
    task automatic run_cfg(input string req, input int a, input int b, input bit en, input bit byp);
        int n, p, w;
        bit e;
        @(negedge clk);
        div_base = 16'(a); div_ext = 4'(b); ovs_sel_en = en; ovs_bypass = byp;
        if (!en)     begin n = 16;    e = 1'b0;   end
        else if (!byp) begin n = b + 1; e = (b < 8); end
        else         begin n = 1;     e = (a < 3); end
        p = a + 2;
        w = 2 * n * p + 3;
        @(posedge clk);
        for (int k = 0; k < w; k++) begin
            @(negedge clk);
            if (e) check(req, {sample_tick, bit_tick, cfg_err}, 3'b001);
            else   check(req, {sample_tick, bit_tick, cfg_err},
                         {((k + 1) % p) == 0, ((k + 1) % (n * p)) == 0, 1'b0});
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {sample_tick, bit_tick, cfg_err}, 3'b000);
        div_base = 16'd5; ovs_sel_en = 1'b1; ovs_bypass = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check("R1", {sample_tick, bit_tick, cfg_err}, 3'b000);
        end
        div_base = '0; ovs_sel_en = 1'b0; ovs_bypass = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        // R2 + R8: sixteen-fold mode
        for (int a = 0; a < 5; a++) run_cfg("R2/R8", a, 3, 1'b0, 1'b0);
        // R5: bypass bit ignored when sel_en = 0
        for (int a = 0; a < 3; a++) run_cfg("R5", a, 9, 1'b0, 1'b1);
        // R3: programmable mode
        for (int a = 0; a < 3; a++)
            for (int b = 8; b < 16; b++) run_cfg("R3/R9", a, b, 1'b1, 1'b0);
        // R6: programmable mode, B too small
        for (int b = 0; b < 8; b++) run_cfg("R6", 1, b, 1'b1, 1'b0);
        // R4: direct mode, B ignored
        for (int a = 3; a < 7; a++)
            for (int b = 0; b < 16; b += 5) run_cfg("R4", a, b, 1'b1, 1'b1);
        // R7: direct mode, A too small
        for (int a = 0; a < 3; a++) run_cfg("R7", a, 2, 1'b1, 1'b1);
        // R8: leaving the error state restarts cleanly
        run_cfg("R8", 4, 10, 1'b1, 1'b0);
        done = 1'b1;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
        end
        done = 1'b1;
    end

    initial begin
        wait (done);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule